// File: doc/BRIEF.md
# Oversampled Serial Receiver with Two-Character Packing

This block receives asynchronous serial frames on a single input line and turns them into parallel data in a 16-bit receive buffer. The line is sampled on an oversampled tick that arrives from an external baud generator. A start edge is confirmed at the middle of the start bit. Each later bit is sampled at its own centre.

A single character of 7, 8 or 9 bits fills the low part of the buffer, and every unused upper bit is zero. In 9-bit mode the extra bit is also shown on its own status output. In packed mode, two 8-bit characters that arrive one after the other are combined into a single 16-bit word. A completion pulse is raised only when that word is complete.

Parity, framing and overrun problems are kept as sticky flags until software reads the status. A busy output shows when a frame is being shifted in. Software reads the buffer through a strobe, and the block uses that strobe to detect overrun.

Top module: `uart_rx_pack`

## Requirements
- R1: The line is sampled once every `OVS` ticks (16 by default), with the start bit confirmed `OVS/2` ticks after the falling edge. If the line is high again at that point, the receiver returns to idle, and nothing is stored or flagged.
- R2: With `char8`=0 and neither packed nor 9-bit mode selected, seven data bits are received LSB first into `rx_buf[6:0]`, and `rx_buf[15:7]` is written as 0.
- R3: With `char8`=1, eight data bits are received LSB first into `rx_buf[7:0]`, and `rx_buf[15:8]` is written as 0.
- R4: With `ext9`=1 and `two_frame`=0, nine data bits are received. The ninth bit lands in `rx_buf[8]` and is also copied to `ninth_bit`. `rx_buf[15:9]` is written as 0.
- R5: With `two_frame`=1, characters are 8 bits regardless of `char8` and `ext9`. The first character goes to `rx_buf[7:0]` and the second to `rx_buf[15:8]`, both written in one update. Nothing is written after the first character alone.
- R6: `par_mode` encoding: 0x = no parity bit, 10 = even, 11 = odd. A parity bit follows the data bits. `par_err` is set when the XOR of the data bits, the parity bit and `par_mode[0]` is 1.
- R7: `stop2`=1 selects two stop bits. `frm_err` is set when the first stop bit samples as 0.
- R8: A buffer update sets the buffer full, and a pulse on `rd_buf` marks it read. An update while the buffer is full sets `ovr_err` and still overwrites the buffer. A read in the same cycle counts as happening first.
- R9: The error flags are sticky and are cleared by a pulse on `rd_stat`. If a new error arrives in the same cycle as the pulse, the flag stays set.
- R10: `rx_done` is a single-cycle pulse in the cycle that `rx_buf` takes new data. `rx_buf` never changes in any other cycle.
- R11: `rx_busy` is high from the confirmed start edge until the frame's last stop sample, and low while idle.
- R12: While `en`=0, the receiver stays idle, nothing is written to the buffer, and a half-filled packed word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling tick, one clock wide |
| rx_in | input | 1 | Serial data line, idle high |
| en | input | 1 | Reception enable |
| char8 | input | 1 | 1 = 8-bit characters, 0 = 7-bit |
| par_mode | input | 2 | Parity mode: 0x none, 10 even, 11 odd |
| stop2 | input | 1 | 1 = two stop bits |
| ext9 | input | 1 | 9-bit character mode |
| two_frame | input | 1 | Pack two 8-bit characters per word |
| rd_buf | input | 1 | Buffer read strobe |
| rd_stat | input | 1 | Status read strobe, clears error flags |
| rx_buf | output | 16 | Receive buffer |
| rx_done | output | 1 | Buffer update pulse |
| rx_busy | output | 1 | Frame being shifted in |
| ninth_bit | output | 1 | Ninth bit of the last 9-bit character |
| par_err | output | 1 | Sticky parity error |
| frm_err | output | 1 | Sticky framing error |
| ovr_err | output | 1 | Sticky overrun error |

## Verification
The bench builds the block with `OVS`=8 and a two-stage synchronizer, and issues a tick every second clock, so one bit lasts 16 clocks. This short bit time is what makes it practical to cover every character length, both stop settings, odd and even parity, packed pairs, enable toggling and back-to-back overrun within the cycle budget. A line pulse of two ticks is shorter than half of an 8-tick bit, so it tests the mid-bit start check directly.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP1,
        RX_STOP2
    } rx_state_e;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[g] <= 1'b1;
                end else if (g == 0) begin
                    chain_q[g] <= line_i;
                end else begin
                    chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign line_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_shift.sv
module uart_rx_shift
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       rx_s,
    input  logic       en_i,
    input  logic       char8_i,
    input  logic [1:0] par_mode_i,
    input  logic       stop2_i,
    input  logic       ext9_i,
    input  logic       two_frame_i,
    output logic       valid_o,
    output logic [8:0] data_o,
    output logic       perr_o,
    output logic       ferr_o,
    output logic       busy_o
);
    localparam int CW   = (OVS > 2) ? $clog2(OVS) : 1;
    localparam int HALF = OVS / 2;

    typedef struct packed {
        rx_state_e  st;
        logic [CW-1:0] cnt;
        logic [3:0] idx;
        logic [8:0] sh;
        logic       acc;
        logic       perr;
        logic       ferr;
        logic       valid;
    } shift_t;

    shift_t q, d;
    logic [3:0] nbits;
    logic       sample;

    always_comb begin
        if (two_frame_i)      nbits = 4'd8;
        else if (ext9_i)      nbits = 4'd9;
        else if (char8_i)     nbits = 4'd8;
        else                  nbits = 4'd7;
        sample = (q.cnt == CW'(OVS-1));

        d = q;
        d.valid = 1'b0;
        if (!en_i) begin
            d.st  = RX_IDLE;
            d.cnt = '0;
        end else if (tick_i) begin
            d.cnt = q.cnt + 1'b1;
            unique case (q.st)
                RX_IDLE: begin
                    d.cnt = '0;
                    if (!rx_s) d.st = RX_START;
                end
                RX_START: begin
                    if (q.cnt == CW'(HALF-1)) begin
                        d.cnt  = '0;
                        d.idx  = '0;
                        d.sh   = '0;
                        d.acc  = 1'b0;
                        d.perr = 1'b0;
                        d.ferr = 1'b0;
                        d.st   = rx_s ? RX_IDLE : RX_DATA;
                    end
                end
                RX_DATA: begin
                    if (sample) begin
                        d.cnt = '0;
                        d.sh  = q.sh | (9'(rx_s) << q.idx);
                        d.acc = q.acc ^ rx_s;
                        d.idx = q.idx + 1'b1;
                        if (q.idx == nbits - 1'b1)
                            d.st = par_mode_i[1] ? RX_PAR : RX_STOP1;
                    end
                end
                RX_PAR: begin
                    if (sample) begin
                        d.cnt  = '0;
                        d.perr = q.acc ^ rx_s ^ par_mode_i[0];
                        d.st   = RX_STOP1;
                    end
                end
                RX_STOP1: begin
                    if (sample) begin
                        d.cnt  = '0;
                        d.ferr = !rx_s;
                        if (stop2_i) begin
                            d.st = RX_STOP2;
                        end else begin
                            d.st    = RX_IDLE;
                            d.valid = 1'b1;
                        end
                    end
                end
                RX_STOP2: begin
                    if (sample) begin
                        d.cnt   = '0;
                        d.st    = RX_IDLE;
                        d.valid = 1'b1;
                    end
                end
                default: d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: RX_IDLE, cnt: '0, idx: '0, sh: '0, acc: 1'b0,
                   perr: 1'b0, ferr: 1'b0, valid: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign valid_o = q.valid;
    assign data_o  = q.sh;
    assign perr_o  = q.perr;
    assign ferr_o  = q.ferr;
    assign busy_o  = (q.st != RX_IDLE);

    // R11
    start_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(!rx_s));

    // R10
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R12
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !busy_o);
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
    parameter int BUF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             two_frame_i,
    input  logic             ext9_i,
    input  logic             valid_i,
    input  logic [8:0]       data_i,
    input  logic             perr_i,
    input  logic             ferr_i,
    input  logic             rd_buf_i,
    input  logic             rd_stat_i,
    output logic [BUF_W-1:0] buf_o,
    output logic             done_o,
    output logic             ninth_o,
    output logic             perr_o,
    output logic             ferr_o,
    output logic             ovr_o
);
    localparam int HB = BUF_W / 2;

    typedef struct packed {
        logic [BUF_W-1:0] data;
        logic [HB-1:0]    low;
        logic             half;
        logic             full;
        logic             done;
        logic             ninth;
        logic             perr;
        logic             ferr;
        logic             ovr;
    } buf_t;

    buf_t q, d;
    logic             commit;
    logic [BUF_W-1:0] word;
    logic             word9;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        commit = 1'b0;
        word   = '0;
        word9  = 1'b0;
        if (rd_buf_i)  d.full = 1'b0;
        if (rd_stat_i) begin
            d.perr = 1'b0;
            d.ferr = 1'b0;
            d.ovr  = 1'b0;
        end
        if (!en_i) d.half = 1'b0;
        if (valid_i) begin
            d.perr = d.perr | perr_i;
            d.ferr = d.ferr | ferr_i;
            if (two_frame_i) begin
                if (!q.half) begin
                    d.low  = data_i[HB-1:0];
                    d.half = 1'b1;
                end else begin
                    d.half = 1'b0;
                    commit = 1'b1;
                    word   = {data_i[HB-1:0], q.low};
                end
            end else begin
                commit = 1'b1;
                word9  = ext9_i & data_i[8];
                word   = BUF_W'({word9, data_i[7:0]});
            end
        end
        if (commit) begin
            if (d.full) d.ovr = 1'b1;
            d.data  = word;
            d.ninth = word9;
            d.full  = 1'b1;
            d.done  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign buf_o   = q.data;
    assign done_o  = q.done;
    assign ninth_o = q.ninth;
    assign perr_o  = q.perr;
    assign ferr_o  = q.ferr;
    assign ovr_o   = q.ovr;

    // R10
    buf_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(buf_o));

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !$past(two_frame_i) && !$past(ext9_i)) |-> (buf_o[BUF_W-1:9] == '0 && !ninth_o));

    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_o && !rd_stat_i) |=> ovr_o);

    // R5
    pair_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && two_frame_i && !q.half) |=> !done_o);
endmodule

// File: rtl/uart_rx_pack.sv
module uart_rx_pack #(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        os_tick,
    input  logic        rx_in,
    input  logic        en,
    input  logic        char8,
    input  logic [1:0]  par_mode,
    input  logic        stop2,
    input  logic        ext9,
    input  logic        two_frame,
    input  logic        rd_buf,
    input  logic        rd_stat,
    output logic [15:0] rx_buf,
    output logic        rx_done,
    output logic        rx_busy,
    output logic        ninth_bit,
    output logic        par_err,
    output logic        frm_err,
    output logic        ovr_err
);
    logic       line_s;
    logic       f_valid;
    logic [8:0] f_data;
    logic       f_perr;
    logic       f_ferr;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (rx_in),
        .line_o (line_s)
    );

    uart_rx_shift #(.OVS(OVS)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (os_tick),
        .rx_s        (line_s),
        .en_i        (en),
        .char8_i     (char8),
        .par_mode_i  (par_mode),
        .stop2_i     (stop2),
        .ext9_i      (ext9),
        .two_frame_i (two_frame),
        .valid_o     (f_valid),
        .data_o      (f_data),
        .perr_o      (f_perr),
        .ferr_o      (f_ferr),
        .busy_o      (rx_busy)
    );

    uart_rx_buffer #(.BUF_W(16)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .two_frame_i (two_frame),
        .ext9_i      (ext9),
        .valid_i     (f_valid),
        .data_i      (f_data),
        .perr_i      (f_perr),
        .ferr_i      (f_ferr),
        .rd_buf_i    (rd_buf),
        .rd_stat_i   (rd_stat),
        .buf_o       (rx_buf),
        .done_o      (rx_done),
        .ninth_o     (ninth_bit),
        .perr_o      (par_err),
        .ferr_o      (frm_err),
        .ovr_o       (ovr_err)
    );
endmodule

// File: tb/sim_uart_rx_pack.sv
module sim_uart_rx_pack;
    localparam int OVS  = 8;
    localparam int TDIV = 2;
    localparam int BITC = OVS * TDIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        os_tick = 1'b0;
    logic        rx_in = 1'b1;
    logic        en = 1'b1, char8 = 1'b1, stop2 = 1'b0, ext9 = 1'b0, two_frame = 1'b0;
    logic [1:0]  par_mode = 2'b00;
    logic        rd_buf = 1'b0, rd_stat = 1'b0;
    logic [15:0] rx_buf;
    logic        rx_done, rx_busy, ninth_bit, par_err, frm_err, ovr_err;

    int n_chk = 0, n_fail = 0, done_seen = 0;
    logic [15:0] e_buf = '0, prev_buf = '0;
    logic        e_full = 0, e_ninth = 0, e_perr = 0, e_ferr = 0, e_ovr = 0, prev_done = 0;
    logic [7:0]  e_low = '0;
    bit          e_half = 0;
    int          e_done = 0;

    uart_rx_pack #(.OVS(OVS), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in), .en(en),
        .char8(char8), .par_mode(par_mode), .stop2(stop2), .ext9(ext9),
        .two_frame(two_frame), .rd_buf(rd_buf), .rd_stat(rd_stat),
        .rx_buf(rx_buf), .rx_done(rx_done), .rx_busy(rx_busy), .ninth_bit(ninth_bit),
        .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err));

    always #10 clk = ~clk;

    always @(posedge clk) os_tick <= ~os_tick;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison of buffer stability and pulse width
    always @(negedge clk) begin
        if (rst_n) begin
            if (!rx_done) check("R10 buffer stable", rx_buf, prev_buf);
            if (rx_done && prev_done) check("R10 single pulse", 1, 0);
            if (rx_done) done_seen++;
        end
        prev_buf  = rx_buf;
        prev_done = rx_done;
    end

    task automatic line_bit(input logic v);
        rx_in = v;
        repeat (BITC) @(negedge clk);
    endtask

    // model of one frame arriving at the buffer
    task automatic model_frame(input logic [8:0] dv, input int nb, input bit pe, input bit fe);
        logic [15:0] w;
        logic        n9;
        if (!en) return;
        e_perr |= pe;
        e_ferr |= fe;
        if (two_frame) begin
            if (!e_half) begin
                e_low = dv[7:0]; e_half = 1; return;
            end
            e_half = 0; w = {dv[7:0], e_low}; n9 = 0;
        end else begin
            n9 = ext9 & dv[8];
            w  = (nb == 7) ? {9'b0, dv[6:0]} : {7'b0, n9, dv[7:0]};
        end
        if (e_full) e_ovr = 1;
        e_buf = w; e_ninth = n9; e_full = 1; e_done++;
    endtask

    task automatic send(input logic [8:0] dv, input bit flip_par, input bit bad_stop);
        int  nb;
        logic p;
        nb = two_frame ? 8 : ext9 ? 9 : char8 ? 8 : 7;
        p  = par_mode[0] ^ flip_par;
        @(negedge clk);
        line_bit(1'b0);
        for (int i = 0; i < nb; i++) begin
            line_bit(dv[i]);
            p ^= dv[i];
            if (i == 1) check("R11 busy in frame", rx_busy, en);
        end
        if (par_mode[1]) line_bit(p);
        line_bit(!bad_stop);
        if (stop2) line_bit(1'b1);
        repeat (2 * BITC) @(negedge clk);
        model_frame(dv, nb, par_mode[1] & flip_par, bad_stop);
    endtask

    task automatic compare_all(input string tag);
        check({tag, " buf"}, rx_buf, e_buf);
        check({tag, " done count"}, done_seen, e_done);
        check("R4 ninth", ninth_bit, e_ninth);
        check("R6 par_err", par_err, e_perr);
        check("R7 frm_err", frm_err, e_ferr);
        check("R8 ovr_err", ovr_err, e_ovr);
        check("R11 busy idle", rx_busy, 0);
    endtask

    task automatic pulse_rd_buf();
        @(negedge clk); rd_buf = 1; @(negedge clk); rd_buf = 0; e_full = 0;
    endtask

    task automatic pulse_rd_stat();
        @(negedge clk); rd_stat = 1; @(negedge clk); rd_stat = 0;
        e_perr = 0; e_ferr = 0; e_ovr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare_all("reset");
        check("R10 reset done", rx_done, 0);

        // R3 8-bit
        send(9'h0A5, 0, 0); compare_all("R3 8bit a5"); pulse_rd_buf();
        send(9'h03C, 0, 0); compare_all("R3 8bit 3c"); pulse_rd_buf();

        // R2 7-bit, top line bit cannot leak
        char8 = 0;
        send(9'h07F, 0, 0); compare_all("R2 7bit 7f"); pulse_rd_buf();
        send(9'h02A, 0, 0); compare_all("R2 7bit 2a"); pulse_rd_buf();
        char8 = 1;

        // R4 9-bit
        ext9 = 1;
        send(9'h1A5, 0, 0); compare_all("R4 ext9 1a5"); pulse_rd_buf();
        send(9'h05A, 0, 0); compare_all("R4 ext9 05a"); pulse_rd_buf();
        ext9 = 0;

        // R6 parity even/odd good and bad
        par_mode = 2'b10;
        send(9'h0C3, 0, 0); compare_all("R6 even ok"); pulse_rd_buf();
        send(9'h0C2, 1, 0); compare_all("R6 even bad"); pulse_rd_buf();
        pulse_rd_stat(); compare_all("R9 clear par");
        par_mode = 2'b11;
        send(9'h017, 0, 0); compare_all("R6 odd ok"); pulse_rd_buf();
        send(9'h017, 1, 0); compare_all("R6 odd bad"); pulse_rd_buf();
        send(9'h011, 0, 0); compare_all("R9 sticky par"); pulse_rd_buf();
        pulse_rd_stat();
        par_mode = 2'b00;

        // R7 framing with two stop bits
        stop2 = 1;
        send(9'h066, 0, 1); compare_all("R7 bad stop"); pulse_rd_buf();
        send(9'h099, 0, 0); compare_all("R7 good 2 stop"); pulse_rd_buf();
        pulse_rd_stat(); compare_all("R9 clear frm");
        stop2 = 0;

        // R8 overrun
        send(9'h011, 0, 0);
        send(9'h022, 0, 0); compare_all("R8 overrun");
        pulse_rd_stat(); compare_all("R9 clear ovr");
        pulse_rd_buf();
        send(9'h033, 0, 0); compare_all("R8 after read");
        pulse_rd_buf();

        // R1 short glitch
        @(negedge clk); rx_in = 0;
        repeat (2 * TDIV) @(negedge clk);
        rx_in = 1;
        repeat (3 * BITC) @(negedge clk);
        compare_all("R1 glitch");
        send(9'h081, 0, 0); compare_all("R1 after glitch"); pulse_rd_buf();

        // R5 two-frame packing
        two_frame = 1; char8 = 0; ext9 = 1;
        send(9'h012, 0, 0); compare_all("R5 first half");
        send(9'h034, 0, 0); compare_all("R5 packed"); pulse_rd_buf();
        check("R5 word", rx_buf, 16'h3412);

        // R12 disable discards half word and ignores frames
        send(9'h0AA, 0, 0);
        en = 0; e_half = 0;
        send(9'h0BB, 0, 0); compare_all("R12 disabled");
        check("R12 busy off", rx_busy, 0);
        en = 1;
        send(9'h0CD, 0, 0);
        send(9'h0EF, 0, 0); compare_all("R12 pair after enable");
        check("R12 word", rx_buf, 16'hEFCD);
        pulse_rd_buf();
        two_frame = 0; char8 = 1; ext9 = 0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule